// File: doc/BRIEF.md
# Battery Temperature Zone Selector

This block sorts a sampled battery temperature into one of six levels: a cold inhibit level, four charging zones and a hot inhibit level. Thresholds use hysteresis. The two outer edges have a wide band of about 10 °C. The three inner edges have a band of 1 °C. From the current level, the block picks the configuration byte of the active charging zone. It decodes that byte into a termination voltage in millivolts and a maximum charge current in milliamps. Charging is inhibited when the temperature is out of range, the thermistor is open, the voltage code is invalid, or no sample has been taken yet.

A sample is taken on each clock edge where `sample_i` is high. The temperature arrives as a signed integer in °C. Converting a thermistor reading into °C is left to the logic upstream. After reset the level is unknown. The first sample places the temperature against the plain thresholds 0, 10, 45, 50 and 60 °C, with no hysteresis.

Top module: `temp_zone_sel`

## Requirements
- R1: During and after reset, until the first sample: `zone_known_o`=0, `zone_o`=0, `charge_inhibit_o`=1, both range flags are 0, and `vterm_mv_o`=`imax_ma_o`=0.
- R2: The first sample after reset classifies without hysteresis. The zone codes are: t<0 gives 0 (cold), t<10 gives 1, t<45 gives 2, t<50 gives 3, t<60 gives 4, and t≥60 gives 5 (hot).
- R3: A charging level drops to 0 when t<0. Level 0 is kept while t<10. From level 0, t=10 gives level 1. `temp_cold_o` is high exactly while the known level is 0.
- R4: A level moves to 5 when t≥60. Level 5 is kept while t≥50. From level 5, t=49 gives level 4. `temp_hot_o` is high exactly while the level is 5.
- R5: Level 2 drops to 1 only when t<10. Level 1 rises to 2 only when t≥11. A sample of 10 keeps either level.
- R6: Level 2 rises to 3 at t≥45. Level 3 falls back to 2 only when t<44. Level 3 rises to 4 at t≥50. Level 4 falls back to 3 only when t<49. One sample may cross several edges.
- R7: Without `sample_i`, the level and the known flag hold, whatever `temp_i` does.
- R8: Charging zone k (1..4) uses byte k-1 of `zone_cfg_i`. Bits [6:4] of the byte are the voltage code: 0→3940, 1→4000, 2→4050, 3→4100, 4→4120, 5→4150, 6→4180 mV. Bit 7 is ignored.
- R9: Bits [3:0] of the active byte are the current code: 0 gives 50 mA, and n from 1 to 15 gives n×100 mA. Outside inhibit the current always lies between 50 and 1500 mA.
- R10: If the thermistor-open input was high at the last sample, charging is inhibited in any zone. The zone index is still tracked.
- R11: A voltage code of 7 in the active zone's byte inhibits charging.
- R12: While charging is inhibited, `vterm_mv_o` and `imax_ma_o` are 0. Either range flag implies inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Take a temperature sample this cycle |
| temp_i | input | TEMP_W | Signed battery temperature in °C |
| therm_open_i | input | 1 | Thermistor open detected |
| zone_cfg_i | input | 32 | Four zone bytes, zone 1 in bits [7:0] |
| zone_o | output | 3 | Level: 0 cold, 1..4 charging zones, 5 hot |
| zone_known_o | output | 1 | At least one sample taken since reset |
| charge_inhibit_o | output | 1 | Charging not allowed |
| temp_cold_o | output | 1 | Cold out-of-range fault |
| temp_hot_o | output | 1 | Hot out-of-range fault |
| vterm_mv_o | output | 13 | Termination voltage in mV |
| imax_ma_o | output | 11 | Maximum charge current in mA |

## Verification
The hardest states to reach are the hysteresis bands. A band only shows up when the temperature approaches it from the far side. So the same sample value must be met once coming up and once coming down, after a walk through the neighbouring levels. The stimulus table is therefore one long temperature walk with no reset in between. It steps onto each band value from both directions and includes large jumps across several edges. Resets between directed cases then cover the first-sample classification at the exact threshold values.

// File: rtl/tz_pkg.sv
package tz_pkg;
  localparam int NUM_ZONES = 4;
  localparam int NUM_EDGES = NUM_ZONES + 1;
  localparam int LVL_W     = $clog2(NUM_EDGES + 1);
  localparam int HOT_LVL   = NUM_EDGES;
  localparam int CFG_BYTE  = 8;
  localparam int CFG_W     = NUM_ZONES * CFG_BYTE;
  localparam int VCODE_W   = 3;
  localparam int ICODE_W   = 4;
  localparam int VMV_W     = 13;
  localparam int IMA_W     = 11;

  // per edge: nominal, threshold to cross upward, threshold to stay above
  localparam int NOM_TH  [NUM_EDGES] = '{0, 10, 45, 50, 60};
  localparam int UP_TH   [NUM_EDGES] = '{10, 11, 45, 50, 60};
  localparam int KEEP_TH [NUM_EDGES] = '{0, 10, 44, 49, 50};

  typedef struct packed {
    logic [VCODE_W-1:0] vcode;
    logic [ICODE_W-1:0] icode;
  } zone_prog_t;
endpackage

// File: rtl/tz_classifier.sv
module tz_classifier
  import tz_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     open_i,
  output logic [LVL_W-1:0]         level_o,
  output logic                     known_o,
  output logic                     open_o
);
  logic [LVL_W-1:0]     level_q;
  logic                 known_q, open_q;
  logic [NUM_EDGES-1:0] above;

  for (genvar b = 0; b < NUM_EDGES; b++) begin : g_edge
    localparam int NOM  = NOM_TH[b];
    localparam int UP   = UP_TH[b];
    localparam int KEEP = KEEP_TH[b];
    logic sit_above;
    assign sit_above = int'(level_q) > b;
    always_comb begin
      if (!known_q)       above[b] = int'(temp_i) >= NOM;
      else if (sit_above) above[b] = int'(temp_i) >= KEEP;
      else                above[b] = int'(temp_i) >= UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      known_q <= 1'b0;
      open_q  <= 1'b0;
    end else if (sample_i) begin
      level_q <= LVL_W'($countones(above));
      known_q <= 1'b1;
      open_q  <= open_i;
    end
  end

  assign level_o = level_q;
  assign known_o = known_q;
  assign open_o  = open_q;
endmodule

// File: rtl/tz_cfg_sel.sv
module tz_cfg_sel
  import tz_pkg::*;
(
  input  logic [LVL_W-1:0] level_i,
  input  logic [CFG_W-1:0] cfg_i,
  output zone_prog_t       prog_o,
  output logic             charge_zone_o
);
  always_comb begin
    prog_o        = '0;
    charge_zone_o = 1'b0;
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (int'(level_i) == z + 1) begin
        prog_o        = zone_prog_t'(cfg_i[z*CFG_BYTE +: VCODE_W+ICODE_W]);
        charge_zone_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tz_code_dec.sv
module tz_code_dec
  import tz_pkg::*;
(
  input  zone_prog_t       prog_i,
  output logic             vvalid_o,
  output logic [VMV_W-1:0] vterm_mv_o,
  output logic [IMA_W-1:0] imax_ma_o
);
  always_comb begin
    vvalid_o = 1'b1;
    unique case (prog_i.vcode)
      3'd0: vterm_mv_o = VMV_W'(3940);
      3'd1: vterm_mv_o = VMV_W'(4000);
      3'd2: vterm_mv_o = VMV_W'(4050);
      3'd3: vterm_mv_o = VMV_W'(4100);
      3'd4: vterm_mv_o = VMV_W'(4120);
      3'd5: vterm_mv_o = VMV_W'(4150);
      3'd6: vterm_mv_o = VMV_W'(4180);
      default: begin
        vterm_mv_o = '0;
        vvalid_o   = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (prog_i.icode == '0) imax_ma_o = IMA_W'(50);
    else                    imax_ma_o = IMA_W'(prog_i.icode) * IMA_W'(100);
  end
endmodule

// File: rtl/temp_zone_sel.sv
module temp_zone_sel
  import tz_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     therm_open_i,
  input  logic [31:0]              zone_cfg_i,
  output logic [2:0]               zone_o,
  output logic                     zone_known_o,
  output logic                     charge_inhibit_o,
  output logic                     temp_cold_o,
  output logic                     temp_hot_o,
  output logic [12:0]              vterm_mv_o,
  output logic [10:0]              imax_ma_o
);
  logic [LVL_W-1:0] level;
  logic             known, open_q, charge_zone, vvalid;
  zone_prog_t       prog;
  logic [VMV_W-1:0] vterm_raw;
  logic [IMA_W-1:0] imax_raw;

  tz_classifier #(.TEMP_W(TEMP_W)) u_cls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .temp_i   (temp_i),
    .open_i   (therm_open_i),
    .level_o  (level),
    .known_o  (known),
    .open_o   (open_q)
  );

  tz_cfg_sel u_sel (
    .level_i       (level),
    .cfg_i         (zone_cfg_i),
    .prog_o        (prog),
    .charge_zone_o (charge_zone)
  );

  tz_code_dec u_dec (
    .prog_i     (prog),
    .vvalid_o   (vvalid),
    .vterm_mv_o (vterm_raw),
    .imax_ma_o  (imax_raw)
  );

  logic inhibit;
  assign inhibit = !known || !charge_zone || open_q || !vvalid;

  assign zone_o           = 3'(level);
  assign zone_known_o     = known;
  assign charge_inhibit_o = inhibit;
  assign temp_cold_o      = known && (level == '0);
  assign temp_hot_o       = int'(level) == HOT_LVL;
  assign vterm_mv_o       = inhibit ? '0 : vterm_raw;
  assign imax_ma_o        = inhibit ? '0 : imax_raw;
endmodule

// File: rtl/tz_zone_sel_chk.sv
module tz_zone_sel_chk #(
  parameter int TEMP_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_i,
  input logic signed [TEMP_W-1:0] temp_i,
  input logic                     therm_open_i,
  input logic [2:0]               zone_o,
  input logic                     zone_known_o,
  input logic                     charge_inhibit_o,
  input logic                     temp_cold_o,
  input logic                     temp_hot_o,
  input logic [12:0]              vterm_mv_o,
  input logic [10:0]              imax_ma_o
);
  AST_UNKNOWN_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zone_known_o |-> charge_inhibit_o); // R1
  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(zone_o) && $stable(zone_known_o)); // R7
  AST_COLD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && (int'(temp_i) < 0) |=> zone_o == 3'd0 && temp_cold_o); // R3
  AST_COLD_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && zone_known_o && zone_o == 3'd0 && (int'(temp_i) < 10) |=> zone_o == 3'd0); // R3
  AST_HOT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && (int'(temp_i) >= 60) |=> zone_o == 3'd5 && temp_hot_o); // R4
  AST_HOT_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && zone_o == 3'd5 && (int'(temp_i) >= 50) |=> zone_o == 3'd5); // R4
  AST_OPEN_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && therm_open_i |=> charge_inhibit_o); // R10
  AST_IMAX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !charge_inhibit_o |-> imax_ma_o >= 11'd50 && imax_ma_o <= 11'd1500); // R9
  AST_INHIBIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    charge_inhibit_o |-> vterm_mv_o == '0 && imax_ma_o == '0); // R12
  AST_FLAG_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_cold_o || temp_hot_o) |-> charge_inhibit_o); // R12
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(temp_cold_o && temp_hot_o)); // R12
endmodule

bind temp_zone_sel tz_zone_sel_chk #(.TEMP_W(TEMP_W)) u_chk (.*);

// File: tb/tb_temp_zone_sel.sv
module tb_temp_zone_sel;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample = 1'b0;
  logic signed [7:0] temp = '0;
  logic              topen = 1'b0;
  logic [31:0]       cfg;
  logic [2:0]        zone;
  logic              known, inh, cold, hot;
  logic [12:0]       mv;
  logic [10:0]       ma;
  int                n_chk = 0, n_bad = 0;

  localparam logic [31:0] CFG_A = {8'h03, 8'h35, 8'h6F, 8'h90};

  always #5 clk = ~clk;

  temp_zone_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .temp_i(temp),
    .therm_open_i(topen), .zone_cfg_i(cfg), .zone_o(zone),
    .zone_known_o(known), .charge_inhibit_o(inh), .temp_cold_o(cold),
    .temp_hot_o(hot), .vterm_mv_o(mv), .imax_ma_o(ma)
  );

  // {temp, open, zone, inhibit, pad}
  localparam int NV = 23;
  localparam logic [15:0] VEC [NV] = '{
    {8'd25,  1'b0, 3'd2, 1'b0, 3'b0},  // R2 first sample
    {8'd10,  1'b0, 3'd2, 1'b0, 3'b0},  // R5
    {8'd9,   1'b0, 3'd1, 1'b0, 3'b0},  // R5
    {8'd10,  1'b0, 3'd1, 1'b0, 3'b0},  // R5
    {8'd11,  1'b0, 3'd2, 1'b0, 3'b0},  // R5
    {8'd45,  1'b0, 3'd3, 1'b0, 3'b0},  // R6
    {8'd44,  1'b0, 3'd3, 1'b0, 3'b0},  // R6
    {8'd43,  1'b0, 3'd2, 1'b0, 3'b0},  // R6
    {8'd50,  1'b0, 3'd4, 1'b0, 3'b0},  // R6 multi-edge
    {8'd49,  1'b0, 3'd4, 1'b0, 3'b0},  // R6
    {8'd48,  1'b0, 3'd3, 1'b0, 3'b0},  // R6
    {8'd59,  1'b0, 3'd4, 1'b0, 3'b0},  // R6
    {8'd60,  1'b0, 3'd5, 1'b1, 3'b0},  // R4
    {8'd50,  1'b0, 3'd5, 1'b1, 3'b0},  // R4
    {8'd49,  1'b0, 3'd4, 1'b0, 3'b0},  // R4
    {8'd0,   1'b0, 3'd1, 1'b0, 3'b0},  // R3
    {8'hFF,  1'b0, 3'd0, 1'b1, 3'b0},  // R3 -1
    {8'd9,   1'b0, 3'd0, 1'b1, 3'b0},  // R3
    {8'd10,  1'b0, 3'd1, 1'b0, 3'b0},  // R3
    {8'hD8,  1'b0, 3'd0, 1'b1, 3'b0},  // R3 -40
    {8'd55,  1'b0, 3'd4, 1'b0, 3'b0},  // R6 jump from cold
    {8'd20,  1'b1, 3'd2, 1'b1, 3'b0},  // R10
    {8'd20,  1'b0, 3'd2, 1'b0, 3'b0}   // R10
  };

  function automatic int exp_mv(input logic [2:0] c);
    case (c)
      3'd0: return 3940; 3'd1: return 4000; 3'd2: return 4050; 3'd3: return 4100;
      3'd4: return 4120; 3'd5: return 4150; 3'd6: return 4180; default: return 0;
    endcase
  endfunction

  function automatic int exp_ma(input logic [3:0] c);
    return (c == 0) ? 50 : int'(c) * 100;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic take(input int t, input logic op);
    @(negedge clk);
    temp   = 8'(t);
    topen  = op;
    sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
  endtask

  // full output check for a zone; expected drive values from cfg bytes
  task automatic check_all(input string req, input int ez, input logic einh);
    logic [7:0] b;
    int emv, ema;
    check({req, " zone"}, int'(zone), ez);
    check({req, " inhibit"}, int'(inh), int'(einh));
    check({req, " cold"}, int'(cold), int'(ez == 0));
    check({req, " hot"}, int'(hot), int'(ez == 5));
    emv = 0; ema = 0;
    if (!einh && ez >= 1 && ez <= 4) begin
      b   = cfg[(ez-1)*8 +: 8];
      emv = exp_mv(b[6:4]);
      ema = exp_ma(b[3:0]);
    end
    check({req, " R8 mv"}, int'(mv), emv);
    check({req, " R9 ma"}, int'(ma), ema);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg = CFG_A;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 known", int'(known), 0);
    check("R1 zone", int'(zone), 0);
    check("R1 inhibit", int'(inh), 1);
    check("R1 cold", int'(cold), 0);
    check("R1 mv", int'(mv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 known after release", int'(known), 0);
    check("R1 inhibit after release", int'(inh), 1);

    for (int i = 0; i < NV; i++) begin
      take(int'($signed(VEC[i][15:8])), VEC[i][7]);
      check_all($sformatf("vec%0d", i), int'(VEC[i][6:4]), VEC[i][3]);
    end
    check("R2 known", int'(known), 1);

    // R7: no sample, temperature moves, nothing changes
    @(negedge clk);
    temp = -8'sd40;
    repeat (3) @(negedge clk);
    check_all("R7 hold", 2, 1'b0);

    // R11: invalid voltage code in active zone 2 (byte 1)
    cfg = CFG_A;
    cfg[14:12] = 3'b111;
    @(negedge clk);
    check_all("R11 bad code", 2, 1'b1);
    cfg = CFG_A;
    @(negedge clk);
    check_all("R11 restored", 2, 1'b0);
    // R8 bit7 ignored: byte0 has bit7 set, zone 1 still 4000 mV
    take(5, 1'b0);
    check("R8 zone1 mv", int'(mv), 4000);
    check("R9 zone1 ma", int'(ma), 50);

    // R2: first-sample thresholds without hysteresis
    do_reset(); take(10, 1'b0);  check_all("R2 t=10", 2, 1'b0);
    do_reset(); take(9, 1'b0);   check_all("R2 t=9", 1, 1'b0);
    do_reset(); take(0, 1'b0);   check_all("R2 t=0", 1, 1'b0);
    do_reset(); take(-1, 1'b0);  check_all("R2 t=-1", 0, 1'b1);
    do_reset(); take(44, 1'b0);  check_all("R2 t=44", 2, 1'b0);
    do_reset(); take(49, 1'b0);  check_all("R2 t=49", 3, 1'b0);
    do_reset(); take(59, 1'b0);  check_all("R2 t=59", 4, 1'b0);
    do_reset(); take(60, 1'b0);  check_all("R2 t=60", 5, 1'b1);
    do_reset(); take(127, 1'b0); check_all("R2 t=127", 5, 1'b1);

    // R10 on first sample, R12 gating with open
    do_reset(); take(30, 1'b1);  check_all("R10 first", 2, 1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule